// File: doc/BRIEF.md
# Fractional Rate Clock Enable Generator

This block derives a slower clock enable from its input clock. Over every window of m input cycles it fires exactly n single-cycle pulses, where n ≤ m. The ratio is given as two programmed constants. The add constant is m−n. The subtract constant is −n, stored as magnitude bits only, because its sign is always negative and is therefore implied. A phase accumulator checks, on each cycle, whether adding the subtract constant would leave it non-negative. If it would, the accumulator takes that step. If it would not, the accumulator adds the add constant and the block emits a pulse.

To keep toggling activity low, software scales both constants by the same left shift. The shift is the field width minus the bit length of (m−n) OR n, which leaves the constants with as many trailing zeros as possible. The ratio does not change, and neither does the pulse pattern. A run control starts and stops division. Dropping run clears the phase, so the pattern restarts from the same point every time. A stretch control replaces the single-cycle pulse with a wide output that stays high while the phase is in its upper half. For ratios up to one half, this gives a duty cycle close to 50%.

Top module: `fdiv_top`

## Requirements
- R1: While run is high and the fields are held, `div_tick` carries exactly n pulses in every m consecutive cycles, counted from the first cycle after run rises. The fields are encoded as follows: `cfg_madd` = (m−n)<<s, and `cfg_msub` = the low W bits of −(n<<s).
- R2: The pulse sequence follows a phase p that starts at 0. Each cycle, a pulse is due when p < n, and p then becomes p+m−n. Otherwise p becomes p−n. The pulse for a step appears on `div_tick` after the first rising edge that samples run high at that step, so the first pulse comes right after run is first sampled.
- R3: For any n/m, the scaled encoding (s = W − bitlen((m−n)|n)) and the unscaled encoding (s = 0) give the same cycle-by-cycle output.
- R4: One edge after run is sampled low, `div_tick` and `div_clk` are low and the phase is zero. Asserting run again restarts the sequence from p = 0.
- R5: With `cfg_stretch` high, `div_clk` is high in every cycle whose step is a pulse, and in every cycle whose next phase p' satisfies 2·p' ≥ m. In all other cycles it is low.
- R6: With `cfg_stretch` low, `div_clk` is identical to `div_tick`.
- R7: A `cfg_msub` field of zero means n = 0, so no pulse is ever emitted.
- R8: When n = m (`cfg_madd` zero), a pulse is emitted on every cycle while running.
- R9: The field width W is a parameter. The same encoding and behaviour hold for W = 13.
- R10: During and immediately after reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_madd | input | W | Add constant, (m−n) scaled |
| cfg_msub | input | W | Subtract constant magnitude, sign implied negative |
| cfg_run | input | 1 | Enables division; low clears the phase |
| cfg_stretch | input | 1 | Selects the wide near-50% output on `div_clk` |
| div_tick | output | 1 | Single-cycle enable pulse, n per m cycles |
| div_clk | output | 1 | Shaped output: pulse or stretched |

## Verification
The bench builds two copies of the block: one at the default 8-bit field width and one at 13 bits. The wide copy reaches shift amounts and scaled constants (up to 6144 for 12/13) that the narrow fields cannot hold. At the default width, the bench runs each ratio once with raw fields and once with scaled fields against an independent phase model. It also covers the corner ratios n = m and n = 0, and the stretch shaping, for both odd and even m.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned FDIV_W_NARROW = 8;
  localparam int unsigned FDIV_W_WIDE   = 13;

  // number of bits needed to hold v (0 for v == 0)
  function automatic int unsigned fdiv_bitlen(input int unsigned v);
    int unsigned len;
    len = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) len = i + 1;
    end
    return len;
  endfunction

  // left shift that fills a field of width w with the ratio constants
  function automatic int unsigned fdiv_fill_shift(input int unsigned diff,
                                                  input int unsigned n,
                                                  input int unsigned w);
    return w - fdiv_bitlen(diff | n);
  endfunction
endpackage

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
  parameter int unsigned W = fdiv_pkg::FDIV_W_NARROW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] madd,
  input  logic [W-1:0] msub,
  output logic         take_add,
  output logic         half_hi,
  output logic [W:0]   acc_q
);
  localparam int unsigned EW = W + 2;

  // restore the implied-negative subtract constant as a positive magnitude
  function automatic logic [W:0] implied_mag(input logic [W-1:0] f);
    return {1'b1, {W{1'b0}}} - {1'b0, f};
  endfunction

  logic          ratio_ok;
  logic [W:0]    sub_mag;
  logic [EW-1:0] acc_ext, trial, add_sum, m_span;
  logic          trial_neg;
  logic [W:0]    acc_d;

  assign ratio_ok  = |msub;
  assign sub_mag   = implied_mag(msub);
  assign acc_ext   = {1'b0, acc_q};
  assign trial     = acc_ext + {2'b11, msub};
  assign trial_neg = trial[EW-1];
  assign add_sum   = acc_ext + {2'b00, madd};
  assign m_span    = {2'b00, madd} + {1'b0, sub_mag};

  always_comb begin
    if (!run)           acc_d = '0;
    else if (!ratio_ok) acc_d = acc_q;
    else if (trial_neg) acc_d = add_sum[W:0];
    else                acc_d = trial[W:0];
  end

  assign take_add = run & ratio_ok & trial_neg;
  assign half_hi  = run & ratio_ok & ({acc_d, 1'b0} >= m_span);

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/fdiv_shaper.sv
module fdiv_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic stretch,
  input  logic take_add,
  input  logic half_hi,
  output logic tick,
  output logic clk_out
);
  logic tick_q, wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      tick_q <= take_add;
      wide_q <= take_add | half_hi;
    end
  end

  assign tick    = tick_q;
  assign clk_out = stretch ? wide_q : tick_q;
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top #(
  parameter int unsigned W = fdiv_pkg::FDIV_W_NARROW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg_madd,
  input  logic [W-1:0] cfg_msub,
  input  logic         cfg_run,
  input  logic         cfg_stretch,
  output logic         div_tick,
  output logic         div_clk
);
  logic       take_add;
  logic       half_hi;
  logic [W:0] acc_q;

  fdiv_phase_acc #(.W(W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cfg_run),
    .madd     (cfg_madd),
    .msub     (cfg_msub),
    .take_add (take_add),
    .half_hi  (half_hi),
    .acc_q    (acc_q)
  );

  fdiv_shaper u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .stretch  (cfg_stretch),
    .take_add (take_add),
    .half_hi  (half_hi),
    .tick     (div_tick),
    .clk_out  (div_clk)
  );
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_run,
  input logic         cfg_stretch,
  input logic [W-1:0] cfg_msub,
  input logic         div_tick,
  input logic         div_clk,
  input logic [W:0]   acc_q
);
  // R4
  run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_run |=> (!div_tick && !div_clk && acc_q == '0));

  // R5
  stretch_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stretch && div_tick) |-> div_clk);

  // R6
  pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_stretch |-> (div_clk == div_tick));

  // R7
  no_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_msub == '0) |=> !div_tick);

  // R2
  tick_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> $past(cfg_run));
endmodule

bind fdiv_top fdiv_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_run     (cfg_run),
  .cfg_stretch (cfg_stretch),
  .cfg_msub    (cfg_msub),
  .div_tick    (div_tick),
  .div_clk     (div_clk),
  .acc_q       (acc_q)
);

// File: tb/sim_fdiv_top.sv
module sim_fdiv_top;
  localparam int W0 = 8;
  localparam int W1 = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W0-1:0] madd0 = '0, msub0 = '0;
  logic [W1-1:0] madd1 = '0, msub1 = '0;
  logic run0 = 1'b0, run1 = 1'b0, str0 = 1'b0, str1 = 1'b0;
  logic t0, c0, t1, c1;

  int total = 0;
  int bad = 0;

  fdiv_top #(.W(W0)) u0 (.clk(clk), .rst_n(rst_n), .cfg_madd(madd0), .cfg_msub(msub0),
    .cfg_run(run0), .cfg_stretch(str0), .div_tick(t0), .div_clk(c0));
  fdiv_top #(.W(W1)) u1 (.clk(clk), .rst_n(rst_n), .cfg_madd(madd1), .cfg_msub(msub1),
    .cfg_run(run1), .cfg_stretch(str1), .div_tick(t1), .div_clk(c1));

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  function automatic int blen(input int v);
    int b = 0;
    int x = v;
    while (x > 0) begin b++; x = x >> 1; end
    return b;
  endfunction

  task automatic set_cfg(input int sel, input int m, input int n, input bit scaled, input bit st);
    int w = sel ? W1 : W0;
    int s = scaled ? (w - blen((m - n) | n)) : 0;
    int fa = (m - n) << s;
    int fs = ((1 << w) - (n << s)) & ((1 << w) - 1);
    @(negedge clk);
    if (sel) begin run1 = 0; madd1 = fa[W1-1:0]; msub1 = fs[W1-1:0]; str1 = st; end
    else     begin run0 = 0; madd0 = fa[W0-1:0]; msub0 = fs[W0-1:0]; str0 = st; end
    repeat (2) @(negedge clk);
  endtask

  // runs periods*m cycles against the phase model; returns first 64 tick bits
  task automatic run_case(input string req, input int sel, input int m, input int n,
                          input bit scaled, input bit st, input int periods,
                          output logic [63:0] pat);
    int p = 0;
    int cnt = 0;
    int miss_t = 0;
    int miss_c = 0;
    pat = '0;
    set_cfg(sel, m, n, scaled, st);
    if (sel) run1 = 1; else run0 = 1;
    for (int k = 0; k < m * periods; k++) begin
      bit pulse, wide;
      int pn;
      logic gt, gc;
      pulse = (p < n);
      pn = pulse ? p + m - n : p - n;
      wide = pulse || (2 * pn >= m);
      p = pn;
      @(posedge clk);
      @(negedge clk);
      gt = sel ? t1 : t0;
      gc = sel ? c1 : c0;
      if (gt !== pulse) miss_t++;
      if (gc !== (st ? wide : pulse)) miss_c++;
      if (gt === 1'b1) cnt++;
      if (k < 64) pat[k] = gt;
    end
    chk({req, " tick pattern mismatches"}, miss_t, 0);
    chk({req, " div_clk mismatches"}, miss_c, 0);
    chk({req, " pulse count"}, cnt, n * periods);
    @(negedge clk);
    if (sel) run1 = 0; else run0 = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 tick in reset", int'(t0), 0);
    chk("R10 clk in reset", int'(c0), 0);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    chk("R10 tick after reset", int'(t0), 0);
    chk("R10 wide tick after reset", int'(t1), 0);
  endtask

  task automatic t_ratios();
    logic [63:0] pa, pb;
    run_case("R1 12/13 scaled", 0, 13, 12, 1, 0, 4, pa);
    run_case("R3 12/13 raw", 0, 13, 12, 0, 0, 4, pb);
    chk("R3 12/13 raw vs scaled", int'(pa == pb), 1);
    run_case("R1 3/8 scaled", 0, 8, 3, 1, 0, 5, pa);
    run_case("R3 3/8 raw", 0, 8, 3, 0, 0, 5, pb);
    chk("R3 3/8 raw vs scaled", int'(pa == pb), 1);
    run_case("R2 5/7 scaled", 0, 7, 5, 1, 0, 6, pa);
    run_case("R3 5/7 raw", 0, 7, 5, 0, 0, 6, pb);
    chk("R3 5/7 raw vs scaled", int'(pa == pb), 1);
    run_case("R6 1/4 pulse mode", 0, 4, 1, 1, 0, 6, pa);
  endtask

  task automatic t_full_ratio();
    logic [63:0] pa;
    run_case("R8 4/4 every cycle", 0, 4, 4, 1, 0, 8, pa);
    chk("R8 all ones", int'(pa[31:0] == 32'hFFFF_FFFF), 1);
  endtask

  task automatic t_zero_n();
    int cnt = 0;
    @(negedge clk);
    run0 = 0; madd0 = 8'd5; msub0 = '0; str0 = 0;
    @(negedge clk);
    run0 = 1;
    repeat (20) begin
      @(posedge clk); @(negedge clk);
      if (t0) cnt++;
    end
    chk("R7 no pulses with zero msub", cnt, 0);
    run0 = 0;
  endtask

  task automatic t_run_gate();
    logic [63:0] pa;
    set_cfg(0, 8, 3, 1, 1);
    run0 = 1;
    repeat (5) @(negedge clk);
    run0 = 0;
    @(posedge clk); @(negedge clk);
    chk("R4 tick low after run drop", int'(t0), 0);
    chk("R4 clk low after run drop", int'(c0), 0);
    repeat (3) @(negedge clk);
    chk("R4 still idle", int'(t0 | c0), 0);
    run_case("R4 restart from zero phase", 0, 8, 3, 1, 1, 3, pa);
  endtask

  task automatic t_stretch();
    logic [63:0] pa;
    run_case("R5 stretch 1/4", 0, 4, 1, 1, 1, 6, pa);
    run_case("R5 stretch 2/7 raw", 0, 7, 2, 0, 1, 5, pa);
    run_case("R5 stretch 3/8", 0, 8, 3, 1, 1, 4, pa);
  endtask

  task automatic t_wide();
    logic [63:0] pa, pb;
    run_case("R9 12/13 at 13 bits", 1, 13, 12, 1, 0, 4, pa);
    run_case("R9 12/13 raw at 13 bits", 1, 13, 12, 0, 0, 4, pb);
    chk("R9 raw vs scaled 13 bits", int'(pa == pb), 1);
    run_case("R9 stretch 2/9 at 13 bits", 1, 9, 2, 1, 1, 4, pa);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ratios();
    t_full_ratio();
    t_zero_n();
    t_run_gate();
    t_stretch();
    t_wide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule